// File: doc/BRIEF.md
# Five-Level Bridge Gate Pattern Generator

This block drives the ten gate signals of an isolated dual-active-bridge DC-DC stage. The high-voltage side is a full bridge driven to three levels (+V, 0, −V). The low-voltage side is a full bridge with an extra bidirectional switch, built from two antiparallel gates, that ties one leg midpoint to the capacitor midpoint. That extra switch gives two more levels (±half). A free-running counter spans one switching period. Comparators on that counter turn fractional timing ratios into the repeating sequence of bridge states.

Ratios are unsigned codes in units of 1/2^FRAC_W of a half period. The low-voltage zero-level width and half-level width are programmed directly. The full-level width is whatever remains of each quarter period. The high-voltage zero width and the signed phase shift between the bridges are also programmable. A direction input selects forward or reverse power flow. Every setting is copied into shadow registers only at a period boundary. Each bridge leg passes through a dead-band stage that delays every turn-on by a programmable number of clocks. The block has no data stream, so all pins are plain control pins with no valid/ready handshake.

Top module: `dab5_gate_gen`

## Requirements
- R1: While rst_ni is low or en_i is low, all ten gate outputs are 0.
- R2: The period is period_i clocks, counted c = 0..period_i−1, and period_i must be even and at least 4. On the first clock edge that sees en_i high, counting starts at c = 0. Every gate output lags the position it encodes by exactly one clock.
- R3: Let H = period_i/2, u = c mod H, and the positive half be c < H. Let T1 = floor(zero_ratio·H/2^FRAC_W) and T2 = floor((zero_ratio+half_ratio)·H/2^FRAC_W). The low-voltage level is zero when u < T1 or u ≥ H−T1. It is half when it is not zero and u < T2 or u ≥ H−T2. Otherwise it is full.
- R4: Low-voltage mapping is as follows. +full drives lvp_hi and lvq_lo. −full drives lvp_lo and lvq_hi. Zero drives both high gates (lvp_hi, lvq_hi) during the leading zero of the positive half and the trailing zero of the negative half. Zero drives both low gates in the other two zero intervals.
- R5: +half drives lvq_lo and aux_pos. −half drives lvq_hi and aux_neg. At these times lvp_hi and lvp_lo are both off, and aux_pos and aux_neg are never on together.
- R6: With rev_i = 1, the low-voltage polarity is inverted: the first half is negative. The zero-leg choice of R4 still follows the half index, and the high-voltage leg Q lags leg P instead of leading it.
- R7: Let S = floor(shift·H/2^FRAC_W), where shift is two's complement with FRAC_W fractional bits. Let qa = (c − S) mod period. hvp_hi is on when qa < H, and hvp_lo is on otherwise.
- R8: Let D = floor(hv_zero_ratio·H/2^FRAC_W). Let qb = (qa + D) mod period when forward and (qa − D) mod period when reverse. hvq_lo is on when qb < H, and hvq_hi is on otherwise.
- R9: A gate turns on dead_i clocks after its leg's request changes to it, provided the request holds that long. A gate turns off with no added delay. The two gates of one leg are never on together.
- R10: All inputs other than en_i are captured while counting is stopped and on the last count of each period. A period never mixes old and new settings.
- R11: At FRAC_W = 8, the reference point (zero and half ratios and the high-voltage zero ratio 43 ≈ 0.167, shift 56 ≈ 0.22) runs at period 2500 (20 kHz from 50 MHz) to the R3–R8 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low reset |
| en_i | input | 1 | run enable; low forces all gates off |
| rev_i | input | 1 | 1 = reverse power flow |
| period_i | input | CNT_W | switching period in clocks (even) |
| zero_ratio_i | input | FRAC_W | low-voltage zero-level width per quarter |
| half_ratio_i | input | FRAC_W | low-voltage half-level width per quarter |
| hv_zero_ratio_i | input | FRAC_W | high-voltage zero width per half |
| shift_i | input | FRAC_W+2 | signed bridge phase shift |
| dead_i | input | DT_W | turn-on delay in clocks |
| lvp_hi_o | output | 1 | low-voltage leg P upper gate |
| lvp_lo_o | output | 1 | low-voltage leg P lower gate |
| lvq_hi_o | output | 1 | low-voltage leg Q upper gate |
| lvq_lo_o | output | 1 | low-voltage leg Q lower gate |
| aux_neg_o | output | 1 | auxiliary gate for negative half level |
| aux_pos_o | output | 1 | auxiliary gate for positive half level |
| hvp_hi_o | output | 1 | high-voltage leg P upper gate |
| hvp_lo_o | output | 1 | high-voltage leg P lower gate |
| hvq_hi_o | output | 1 | high-voltage leg Q upper gate |
| hvq_lo_o | output | 1 | high-voltage leg Q lower gate |

## Verification
The bench sweeps several points that are easy to get wrong. Zero ratios of 0 and the half-level ratio filling the whole quarter both collapse an interval. The extreme shifts ±1 wrap the high-voltage phase fully around. Ratio products that land off whole clocks expose a floor that was rounded instead, which would move a level edge by one clock. It changes settings mid-period: a design that latched them immediately would produce a torn period. It also runs with non-zero dead time and in reverse, where a swapped auxiliary gate or a wrong lag direction would show as a mismatched gate on the second half.

// File: rtl/dab5_pkg.sv
package dab5_pkg;
  // Request for one leg: off, side A on, side B on.
  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_A   = 2'd1,
    DRV_B   = 2'd2
  } drv_e;

  // Leg order used by the top: LV P, LV Q, auxiliary, HV P, HV Q.
  localparam int NUM_LEGS = 5;
  localparam int LEG_LVP  = 0;
  localparam int LEG_LVQ  = 1;
  localparam int LEG_AUX  = 2;
  localparam int LEG_HVP  = 3;
  localparam int LEG_HVQ  = 4;
endpackage

// File: rtl/dab5_timer.sv
module dab5_timer #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int DT_W   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     rev_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [FRAC_W-1:0]        zr_i,
  input  logic [FRAC_W-1:0]        hr_i,
  input  logic [FRAC_W-1:0]        hz_i,
  input  logic signed [FRAC_W+1:0] sh_i,
  input  logic [DT_W-1:0]          dead_i,
  output logic                     run_o,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     rev_o,
  output logic [CNT_W-1:0]         period_o,
  output logic [FRAC_W-1:0]        zr_o,
  output logic [FRAC_W-1:0]        hr_o,
  output logic [FRAC_W-1:0]        hz_o,
  output logic signed [FRAC_W+1:0] sh_o,
  output logic [DT_W-1:0]          dead_o
);
  logic                     run_q;
  logic [CNT_W-1:0]         cnt_q;
  logic                     rev_q;
  logic [CNT_W-1:0]         per_q;
  logic [FRAC_W-1:0]        zr_q, hr_q, hz_q;
  logic signed [FRAC_W+1:0] sh_q;
  logic [DT_W-1:0]          dead_q;
  logic                     last;
  logic                     load;

  assign last = run_q && (cnt_q >= per_q - CNT_W'(1));
  assign load = !run_q || last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rev_q  <= 1'b0;
      per_q  <= '0;
      zr_q   <= '0;
      hr_q   <= '0;
      hz_q   <= '0;
      sh_q   <= '0;
      dead_q <= '0;
    end else begin
      if (!en_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (!run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (last) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (load) begin
        rev_q  <= rev_i;
        per_q  <= period_i;
        zr_q   <= zr_i;
        hr_q   <= hr_i;
        hz_q   <= hz_i;
        sh_q   <= sh_i;
        dead_q <= dead_i;
      end
    end
  end

  assign run_o    = run_q;
  assign cnt_o    = cnt_q;
  assign rev_o    = rev_q;
  assign period_o = per_q;
  assign zr_o     = zr_q;
  assign hr_o     = hr_q;
  assign hz_o     = hz_q;
  assign sh_o     = sh_q;
  assign dead_o   = dead_q;

  // R2: counter stays inside the captured period
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < per_q));

  // R2: counting restarts at zero when the run begins
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (cnt_q == '0));

  // R10: settings only move at a period boundary
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !$past(last)) |->
      ($stable(zr_q) && $stable(hr_q) && $stable(hz_q) && $stable(sh_q) &&
       $stable(rev_q) && $stable(per_q) && $stable(dead_q)));
endmodule

// File: rtl/dab5_lv_pattern.sv
module dab5_lv_pattern
  import dab5_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [FRAC_W-1:0] zr_i,
  input  logic [FRAC_W-1:0] hr_i,
  input  logic              rev_i,
  output drv_e              lvp_o,
  output drv_e              lvq_o,
  output drv_e              aux_o
);
  localparam int PW = CNT_W + FRAC_W;

  logic [CNT_W-1:0]  half;
  logic [FRAC_W:0]   sum12;
  logic [PW-1:0]     p1;
  logic [PW:0]       p12;
  logic [CNT_W-1:0]  t1, t12, u;
  logic              second, early, in_zero, in_half, neg;

  always_comb begin
    half    = period_i >> 1;
    sum12   = {1'b0, zr_i} + {1'b0, hr_i};
    p1      = {{CNT_W{1'b0}}, zr_i} * {{FRAC_W{1'b0}}, half};
    p12     = {{CNT_W{1'b0}}, sum12} * {{(FRAC_W + 1){1'b0}}, half};
    t1      = CNT_W'(p1 >> FRAC_W);
    t12     = CNT_W'(p12 >> FRAC_W);
    second  = (cnt_i >= half);
    u       = second ? (cnt_i - half) : cnt_i;
    early   = (u < t1);
    in_zero = early || (u >= half - t1);
    in_half = (u < t12) || (u >= half - t12);
    neg     = second ^ rev_i;

    lvp_o = DRV_OFF;
    lvq_o = DRV_OFF;
    aux_o = DRV_OFF;
    if (run_i) begin
      if (in_zero) begin
        // both upper gates at the leading zero of half 0 and trailing zero of half 1
        if (early != second) begin
          lvp_o = DRV_A;
          lvq_o = DRV_A;
        end else begin
          lvp_o = DRV_B;
          lvq_o = DRV_B;
        end
      end else if (in_half) begin
        if (neg) begin
          lvq_o = DRV_A;
          aux_o = DRV_A;
        end else begin
          lvq_o = DRV_B;
          aux_o = DRV_B;
        end
      end else begin
        lvp_o = neg ? DRV_B : DRV_A;
        lvq_o = neg ? DRV_A : DRV_B;
      end
    end
  end
endmodule

// File: rtl/dab5_hv_pattern.sv
module dab5_hv_pattern
  import dab5_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic                     run_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [FRAC_W-1:0]        hz_i,
  input  logic signed [FRAC_W+1:0] sh_i,
  input  logic                     rev_i,
  output drv_e                     hvp_o,
  output drv_e                     hvq_o
);
  localparam int SW = CNT_W + FRAC_W + 3;
  localparam int PW = CNT_W + FRAC_W;

  logic [CNT_W-1:0]     half;
  logic [PW-1:0]        p4;
  logic signed [SW-1:0] prod, shift_c, half_s, per_s, cnt_s, d4c;
  logic signed [SW-1:0] qa_raw, qa, qb_raw, qb;

  always_comb begin
    half    = period_i >> 1;
    half_s  = $signed({{(SW - CNT_W){1'b0}}, half});
    per_s   = $signed({{(SW - CNT_W){1'b0}}, period_i});
    cnt_s   = $signed({{(SW - CNT_W){1'b0}}, cnt_i});
    prod    = $signed({{(SW - FRAC_W - 2){sh_i[FRAC_W+1]}}, sh_i}) * half_s;
    shift_c = prod >>> FRAC_W;
    p4      = {{CNT_W{1'b0}}, hz_i} * {{FRAC_W{1'b0}}, half};
    d4c     = $signed({{(SW - PW){1'b0}}, (p4 >> FRAC_W)});

    qa_raw = cnt_s - shift_c;
    if (qa_raw < 0)           qa = qa_raw + per_s;
    else if (qa_raw >= per_s) qa = qa_raw - per_s;
    else                      qa = qa_raw;

    qb_raw = rev_i ? (qa - d4c) : (qa + d4c);
    if (qb_raw < 0)           qb = qb_raw + per_s;
    else if (qb_raw >= per_s) qb = qb_raw - per_s;
    else                      qb = qb_raw;

    hvp_o = DRV_OFF;
    hvq_o = DRV_OFF;
    if (run_i) begin
      hvp_o = (qa < half_s) ? DRV_A : DRV_B;
      hvq_o = (qb < half_s) ? DRV_B : DRV_A;
    end
  end
endmodule

// File: rtl/dab5_deadband.sv
module dab5_deadband
  import dab5_pkg::*;
#(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  drv_e            req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            a_o,
  output logic            b_o
);
  drv_e            st_q;
  logic [DT_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DRV_OFF;
      age_q <= '0;
    end else if (req_i != st_q) begin
      st_q  <= req_i;
      age_q <= '0;
    end else if (age_q != '1) begin
      age_q <= age_q + DT_W'(1);
    end
  end

  assign a_o = en_i && (st_q == DRV_A) && (age_q >= dead_i);
  assign b_o = en_i && (st_q == DRV_B) && (age_q >= dead_i);

  // R9: the two gates of a leg never conduct together
  a_r9_leg_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_o && b_o));

  // R9: with a dead time set, a turn-on never follows the partner directly
  a_r9_gap_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dead_i != '0) && $rose(a_o)) |-> !$past(b_o));

  a_r9_gap_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dead_i != '0) && $rose(b_o)) |-> !$past(a_o));
endmodule

// File: rtl/dab5_gate_gen.sv
module dab5_gate_gen
  import dab5_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int DT_W   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     rev_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [FRAC_W-1:0]        zero_ratio_i,
  input  logic [FRAC_W-1:0]        half_ratio_i,
  input  logic [FRAC_W-1:0]        hv_zero_ratio_i,
  input  logic signed [FRAC_W+1:0] shift_i,
  input  logic [DT_W-1:0]          dead_i,
  output logic                     lvp_hi_o,
  output logic                     lvp_lo_o,
  output logic                     lvq_hi_o,
  output logic                     lvq_lo_o,
  output logic                     aux_neg_o,
  output logic                     aux_pos_o,
  output logic                     hvp_hi_o,
  output logic                     hvp_lo_o,
  output logic                     hvq_hi_o,
  output logic                     hvq_lo_o
);
  logic                     run;
  logic [CNT_W-1:0]         cnt, per_s;
  logic                     rev_s;
  logic [FRAC_W-1:0]        zr_s, hr_s, hz_s;
  logic signed [FRAC_W+1:0] sh_s;
  logic [DT_W-1:0]          dead_s;
  drv_e                     req [NUM_LEGS];
  logic [NUM_LEGS-1:0]      ga, gb;

  dab5_timer #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .DT_W(DT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .rev_i    (rev_i),
    .period_i (period_i),
    .zr_i     (zero_ratio_i),
    .hr_i     (half_ratio_i),
    .hz_i     (hv_zero_ratio_i),
    .sh_i     (shift_i),
    .dead_i   (dead_i),
    .run_o    (run),
    .cnt_o    (cnt),
    .rev_o    (rev_s),
    .period_o (per_s),
    .zr_o     (zr_s),
    .hr_o     (hr_s),
    .hz_o     (hz_s),
    .sh_o     (sh_s),
    .dead_o   (dead_s)
  );

  dab5_lv_pattern #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_lv (
    .run_i    (run),
    .cnt_i    (cnt),
    .period_i (per_s),
    .zr_i     (zr_s),
    .hr_i     (hr_s),
    .rev_i    (rev_s),
    .lvp_o    (req[LEG_LVP]),
    .lvq_o    (req[LEG_LVQ]),
    .aux_o    (req[LEG_AUX])
  );

  dab5_hv_pattern #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_hv (
    .run_i    (run),
    .cnt_i    (cnt),
    .period_i (per_s),
    .hz_i     (hz_s),
    .sh_i     (sh_s),
    .rev_i    (rev_s),
    .hvp_o    (req[LEG_HVP]),
    .hvq_o    (req[LEG_HVQ])
  );

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    dab5_deadband #(.DT_W(DT_W)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .req_i  (req[i]),
      .dead_i (dead_s),
      .a_o    (ga[i]),
      .b_o    (gb[i])
    );
  end

  assign lvp_hi_o  = ga[LEG_LVP];
  assign lvp_lo_o  = gb[LEG_LVP];
  assign lvq_hi_o  = ga[LEG_LVQ];
  assign lvq_lo_o  = gb[LEG_LVQ];
  assign aux_neg_o = ga[LEG_AUX];
  assign aux_pos_o = gb[LEG_AUX];
  assign hvp_hi_o  = ga[LEG_HVP];
  assign hvp_lo_o  = gb[LEG_HVP];
  assign hvq_hi_o  = ga[LEG_HVQ];
  assign hvq_lo_o  = gb[LEG_HVQ];

  // R5: the two auxiliary gates are mutually exclusive
  a_r5_aux_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({aux_neg_o, aux_pos_o}));

  // R5: leg P of the low-voltage bridge is off while the auxiliary path conducts
  a_r5_aux_legp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_neg_o || aux_pos_o) |-> !(lvp_hi_o || lvp_lo_o));
endmodule

// File: tb/sim_dab5_gate_gen.sv
module sim_dab5_gate_gen;
  localparam int CW = 16;
  localparam int FW = 8;
  localparam int DW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n, en, rev;
  logic [CW-1:0]        per;
  logic [FW-1:0]        d_zero, d_half, d_hvz;
  logic signed [FW+1:0] d_sh;
  logic [DW-1:0]        dt;
  logic lvp_hi, lvp_lo, lvq_hi, lvq_lo, aux_n, aux_p, hvp_hi, hvp_lo, hvq_hi, hvq_lo;

  dab5_gate_gen #(.CNT_W(CW), .FRAC_W(FW), .DT_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rev_i(rev), .period_i(per),
    .zero_ratio_i(d_zero), .half_ratio_i(d_half), .hv_zero_ratio_i(d_hvz),
    .shift_i(d_sh), .dead_i(dt),
    .lvp_hi_o(lvp_hi), .lvp_lo_o(lvp_lo), .lvq_hi_o(lvq_hi), .lvq_lo_o(lvq_lo),
    .aux_neg_o(aux_n), .aux_pos_o(aux_p), .hvp_hi_o(hvp_hi), .hvp_lo_o(hvp_lo),
    .hvq_hi_o(hvq_hi), .hvq_lo_o(hvq_lo)
  );

  int    checks = 0;
  int    errors = 0;
  string tag;

  // bench model state (codes: 0 off, 1 side A, 2 side B)
  int m_run, m_cnt, m_rev, m_per, m_z, m_h, m_hz, m_sh, m_dt;
  int st [5];
  int age [5];
  int rq [5];

  task automatic model_reset();
    m_run = 0; m_cnt = 0; m_rev = 0; m_per = 0; m_z = 0; m_h = 0;
    m_hz = 0; m_sh = 0; m_dt = 0;
    for (int i = 0; i < 5; i++) begin st[i] = 0; age[i] = 0; end
  endtask

  task automatic compute_req();
    int hh, u, sec, zero, inner, neg, qa, qb, sft, dd;
    for (int i = 0; i < 5; i++) rq[i] = 0;
    if (m_run != 0) begin
      hh    = m_per / 2;
      sec   = (m_cnt >= hh) ? 1 : 0;
      u     = sec ? m_cnt - hh : m_cnt;
      // R3: level boundaries from floor(ratio*H/256)
      zero  = (((u + 1) * 256 <= m_z * hh) || ((hh - u) * 256 <= m_z * hh)) ? 1 : 0;
      inner = (((u + 1) * 256 <= (m_z + m_h) * hh) ||
               ((hh - u) * 256 <= (m_z + m_h) * hh)) ? 1 : 0;
      neg   = sec ^ m_rev;
      if (zero != 0) begin
        // R4: leading zero of half 0 / trailing zero of half 1 use both upper gates
        if ((((u + 1) * 256 <= m_z * hh) ? 1 : 0) != sec) begin rq[0] = 1; rq[1] = 1; end
        else begin rq[0] = 2; rq[1] = 2; end
      end else if (inner != 0) begin
        // R5: half level
        if (neg != 0) begin rq[1] = 1; rq[2] = 1; end
        else begin rq[1] = 2; rq[2] = 2; end
      end else begin
        rq[0] = neg ? 2 : 1;
        rq[1] = neg ? 1 : 2;
      end
      // R7 / R8: high-voltage legs
      sft = int'($floor(real'(m_sh) * real'(hh) / 256.0));
      dd  = (m_hz * hh) / 256;
      qa  = ((m_cnt - sft) % m_per + m_per) % m_per;
      qb  = (m_rev != 0) ? (qa - dd + m_per) % m_per : (qa + dd) % m_per;
      rq[3] = (qa < hh) ? 1 : 2;
      rq[4] = (qb < hh) ? 2 : 1;
    end
  endtask

  task automatic check_pair(input string grp, input int leg, input logic a, input logic b);
    logic ea, eb;
    ea = en && (st[leg] == 1) && (age[leg] >= m_dt);
    eb = en && (st[leg] == 2) && (age[leg] >= m_dt);
    checks++;
    if (a !== ea || b !== eb) begin
      errors++;
      $display("FAIL %s [%s] leg %0d cnt %0d: actual %b%b expected %b%b",
               grp, tag, leg, m_cnt, a, b, ea, eb);
    end
  endtask

  task automatic compare();
    check_pair("R3 R4", 0, lvp_hi, lvp_lo);
    check_pair("R3 R4", 1, lvq_hi, lvq_lo);
    check_pair("R5",    2, aux_n,  aux_p);
    check_pair("R7",    3, hvp_hi, hvp_lo);
    check_pair("R8",    4, hvq_hi, hvq_lo);
  endtask

  task automatic tick();
    int was_run, was_last;
    compute_req();
    @(posedge clk);
    if (!rst_n) begin
      model_reset();
    end else begin
      for (int i = 0; i < 5; i++) begin
        if (rq[i] != st[i]) begin st[i] = rq[i]; age[i] = 0; end
        else if (age[i] < 63) age[i]++;
      end
      was_run  = m_run;
      was_last = (m_run != 0 && m_cnt >= m_per - 1) ? 1 : 0;
      if (!en) begin m_run = 0; m_cnt = 0; end
      else if (m_run == 0) begin m_run = 1; m_cnt = 0; end
      else if (was_last != 0) m_cnt = 0;
      else m_cnt++;
      // R10: capture only when stopped or at the last count
      if (was_run == 0 || was_last != 0) begin
        m_rev = rev; m_per = per; m_z = d_zero; m_h = d_half; m_hz = d_hvz;
        m_sh = d_sh; m_dt = dt;
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic set_cfg(input int p, input int z, input int h, input int hz,
                         input int s, input int r, input int t);
    per = CW'(p); d_zero = FW'(z); d_half = FW'(h); d_hvz = FW'(hz);
    d_sh = (FW+2)'(s); rev = r[0]; dt = DW'(t);
  endtask

  task automatic run_sweep(input int r);
    int zs [4] = '{0, 43, 96, 128};
    int ss [5] = '{-256, -77, 0, 56, 256};
    int hzs [3] = '{0, 43, 128};
    int ps [2] = '{24, 64};
    int hs [3];
    for (int pi = 0; pi < 2; pi++)
      for (int zi = 0; zi < 4; zi++) begin
        hs = '{0, 43, 128 - zs[zi]};
        for (int hi = 0; hi < 3; hi++)
          for (int ki = 0; ki < 3; ki++)
            for (int si = 0; si < 5; si++) begin
              if (zs[zi] + hs[hi] <= 128) begin
                set_cfg(ps[pi], zs[zi], hs[hi], hzs[ki], ss[si], r, 0);
                repeat (2 * ps[pi] + 3) tick();
              end
            end
      end
  endtask

  initial begin
    #(190000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0;
    en    = 1'b1;
    set_cfg(64, 43, 43, 43, 56, 0, 0);

    // R1: outputs low during reset
    tag = "R1 reset";
    repeat (4) tick();
    checks++;
    if ({lvp_hi, lvp_lo, lvq_hi, lvq_lo, aux_n, aux_p, hvp_hi, hvp_lo, hvq_hi, hvq_lo} !== 10'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b expected 0000000000",
               {lvp_hi, lvp_lo, lvq_hi, lvq_lo, aux_n, aux_p, hvp_hi, hvp_lo, hvq_hi, hvq_lo});
    end
    rst_n = 1'b1;

    // R2: start from count zero, steady forward periods
    tag = "R2 start";
    repeat (200) tick();

    // R3 R4 R5 R7 R8: forward sweep
    tag = "R3 R4 R5 R7 R8 forward sweep";
    run_sweep(0);

    // R6: reverse sweep
    tag = "R6 reverse sweep";
    run_sweep(1);

    // R9: dead time in both directions
    tag = "R9 dead time";
    for (int di = 0; di < 3; di++)
      for (int r = 0; r < 2; r++) begin
        set_cfg(64, 20, 60, 43, -90, r, (di == 0) ? 1 : (di == 1) ? 3 : 7);
        repeat (200) tick();
      end

    // R10: settings move every 17 clocks, only boundaries may apply them
    tag = "R10 mid-period change";
    for (int k = 0; k < 20; k++) begin
      set_cfg((k % 2 == 0) ? 40 : 48, (k * 13) % 64, (k * 7) % 64, (k * 11) % 128,
              (k * 37) % 400 - 200, k % 3 == 0 ? 1 : 0, k % 4);
      repeat (17) tick();
    end

    // R1 R2: enable drop then restart mid-period
    tag = "R1 R2 enable toggle";
    set_cfg(64, 43, 43, 43, 56, 0, 2);
    repeat (50) tick();
    en = 1'b0;
    repeat (20) tick();
    en = 1'b1;
    repeat (150) tick();

    // R11: reference point at 20 kHz from 50 MHz
    tag = "R11 reference point";
    set_cfg(2500, 43, 43, 43, 56, 0, 5);
    repeat (5100) tick();
    set_cfg(2500, 43, 43, 43, 56, 1, 5);
    repeat (5100) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule